// File: doc/BRIEF.md
# Daisy-Chain Potentiometer SPI Host Sequencer

This block is an SPI mode-0 master for a string of identical digital potentiometer slaves. All the slaves share one chip select and one serial clock. The data output of each slave feeds the data input of the next one. The device nearest the host is device 0, and the device at the far end is device `N_DEV-1`. The far-end device's output returns to the host's `miso`.

The user side presents one command per device: a read flag, a 5-bit register address and an 8-bit write value. It then pulses `start`.

- **Write-only transaction.** The sequencer opens one chip-select window of `N_DEV` two-byte frames, sent in reversed chain order.
- **Transaction with at least one read.** After the first window and a deselect gap, a second window of `N_DEV` NOP frames follows. The echoed frames are captured from `miso` during this second window. Each one is matched back to its device and checked against its echoed opcode and address.
- **Completion.** Results appear with a one-cycle `done` pulse.

All bus timing is derived from one divider parameter, `SCK_HALF`, the number of core clocks in each SCK phase:

| Interval | Length (core clocks) |
|---|---|
| SCK high or low phase | `SCK_HALF` |
| Lead (chip select falls to first SCK rise) | `3*SCK_HALF` |
| Lag (last SCK fall to chip select rise) | `3*SCK_HALF` |
| Deselect gap | `20*SCK_HALF` |

With a 200 ns SCK period these intervals meet 250 ns lead and lag and a 2 µs deselect time.

Top module: `chain_pot_master`

## Requirements
- R1: After reset, `cs_n`=1, `sck`=0, `mosi`=0, `busy`=0, `done`=0, and `rd_data` and `rd_err` are all zero.
- R2: A transaction opens a first chip-select window of exactly `16*N_DEV` SCK rising edges. The frame for device `N_DEV-1` is shifted first and the frame for device 0 last. Each frame is sent MSB first as 3 opcode bits, then the 5 address bits, then 8 data bits. A write frame carries opcode 110b and the device's write value.
- R3: A device whose read flag is set gets opcode 100b and data byte 00h in the first window.
- R4: `sck` is low whenever `cs_n` is high. `mosi` never changes while `sck` stays high. `miso` is sampled when `sck` rises.
- R5: Each SCK phase lasts `SCK_HALF` clocks. The first rise comes `3*SCK_HALF` clocks after `cs_n` falls. `cs_n` rises `3*SCK_HALF` clocks after the last SCK fall. `cs_n` stays high at least `20*SCK_HALF` clocks between windows.
- R6: If no read flag is set, the transaction has one window. Otherwise a second window of `16*N_DEV` rising edges follows, with `mosi` held at 0 (NOP opcode 000b, data 00h).
- R7: In the second window, received frame k (counting from 0) belongs to device `N_DEV-1-k`. A reading device's `rd_data` is the second byte of its frame.
- R8: A reading device's `rd_err` bit is 1 exactly when the first byte of its frame is not 111b followed by its requested address.
- R9: For a device without a read flag, `rd_data` is 00h and `rd_err` is 0 after the transaction.
- R10: A `start` pulse while `busy` is 1 is ignored. The running stream is unchanged and no further window follows.
- R11: `done` is high for exactly one cycle at the end of each transaction. `busy` is 0 in that cycle, and the results are valid from that cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a transaction when idle |
| cmd_rd | input | N_DEV | Per-device read flag |
| cmd_addr | input | 5*N_DEV | Per-device register address, device d at [5d+:5] |
| cmd_data | input | 8*N_DEV | Per-device write value, device d at [8d+:8] |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8*N_DEV | Per-device read result, device d at [8d+:8] |
| rd_err | output | N_DEV | Per-device echo mismatch flag |
| sck | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Shared active-low chip select |
| mosi | output | 1 | Serial data to device 0 |
| miso | input | 1 | Serial data from device N_DEV-1 |

## Verification
`start` is driven on a falling core-clock edge and is accepted at the next rising edge. At that same edge `cs_n` falls and the first bit is placed on `mosi`.

| Event | When it is due (core clocks) |
|---|---|
| First SCK rise | lead count after `cs_n` falls |
| Each later edge | `SCK_HALF` after the previous edge |
| `cs_n` rise | lag count after the last fall |
| `done` and registered results | deselect gap after the final `cs_n` rise |

The bench counts these intervals on falling core-clock edges, so each count equals the number of cycles an output held its level. It compares `done` and the results at the first falling edge where `done` is 1, and checks that `done` is 0 one edge later. The sweep covers every read mask of a three-device chain, with good and corrupted echoes.

// File: rtl/chain_pot_pkg.sv
package chain_pot_pkg;
  localparam int FRAME_W = 16;
  localparam int ADDR_W  = 5;
  localparam int DATA_W  = 8;

  localparam logic [2:0] OP_WR   = 3'b110;
  localparam logic [2:0] OP_RD   = 3'b100;
  localparam logic [2:0] OP_ECHO = 3'b111;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_HIGH, ST_LOW, ST_LAG, ST_GAP
  } seq_state_e;

  // bus interval lengths in core clocks, all derived from the half period
  function automatic int lead_cycles(input int half);
    return 3 * half;
  endfunction
  function automatic int lag_cycles(input int half);
    return 3 * half;
  endfunction
  function automatic int gap_cycles(input int half);
    return 20 * half;
  endfunction

  // outgoing frame of the first window
  function automatic logic [FRAME_W-1:0] make_frame(input logic is_rd,
                                                    input logic [ADDR_W-1:0] addr,
                                                    input logic [DATA_W-1:0] data);
    return is_rd ? {OP_RD, addr, 8'h00} : {OP_WR, addr, data};
  endfunction

  // echo byte mismatch of a returned frame
  function automatic logic echo_bad(input logic [FRAME_W-1:0] resp,
                                    input logic [ADDR_W-1:0] addr);
    return resp[FRAME_W-1 -: 8] != {OP_ECHO, addr};
  endfunction
endpackage

// File: rtl/chain_pot_pack.sv
module chain_pot_pack
  import chain_pot_pkg::*;
#(
  parameter int N_DEV = 4
) (
  input  logic [N_DEV-1:0]           cmd_rd,
  input  logic [N_DEV*ADDR_W-1:0]    cmd_addr,
  input  logic [N_DEV*DATA_W-1:0]    cmd_data,
  output logic [N_DEV*FRAME_W-1:0]   tx_word
);
  // device d sits at [16d+:16]; the top frame (device N_DEV-1) leaves first
  for (genvar d = 0; d < N_DEV; d++) begin : g_frame
    assign tx_word[d*FRAME_W +: FRAME_W] =
      make_frame(cmd_rd[d], cmd_addr[d*ADDR_W +: ADDR_W], cmd_data[d*DATA_W +: DATA_W]);
  end
endmodule

// File: rtl/chain_pot_unpack.sv
module chain_pot_unpack
  import chain_pot_pkg::*;
#(
  parameter int N_DEV = 4
) (
  input  logic [N_DEV*FRAME_W-1:0] rx_word,
  input  logic [N_DEV-1:0]         rd_mask,
  input  logic [N_DEV*ADDR_W-1:0]  addr_flat,
  output logic [N_DEV*DATA_W-1:0]  data_flat,
  output logic [N_DEV-1:0]         err_flat
);
  // first received frame lands in the top slice, which belongs to device N_DEV-1
  for (genvar d = 0; d < N_DEV; d++) begin : g_dev
    assign data_flat[d*DATA_W +: DATA_W] =
      rd_mask[d] ? rx_word[d*FRAME_W +: DATA_W] : '0;
    assign err_flat[d] =
      rd_mask[d] & echo_bad(rx_word[d*FRAME_W +: FRAME_W], addr_flat[d*ADDR_W +: ADDR_W]);
  end
endmodule

// File: rtl/chain_pot_engine.sv
module chain_pot_engine
  import chain_pot_pkg::*;
#(
  parameter int N_DEV    = 4,
  parameter int SCK_HALF = 20
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       need_rd,
  input  logic [N_DEV*FRAME_W-1:0]   tx_word,
  input  logic                       miso,
  output logic                       sck,
  output logic                       cs_n,
  output logic                       mosi,
  output logic                       busy,
  output logic                       accept,
  output logic                       fin,
  output logic [N_DEV*FRAME_W-1:0]   rx_word
);
  localparam int W        = N_DEV * FRAME_W;
  localparam int LEAD_CYC = lead_cycles(SCK_HALF);
  localparam int LAG_CYC  = lag_cycles(SCK_HALF);
  localparam int GAP_CYC  = gap_cycles(SCK_HALF);
  localparam int CNT_W    = $clog2(GAP_CYC) + 1;
  localparam int BIT_W    = $clog2(W);
  localparam logic [CNT_W-1:0] LEAD_LD = CNT_W'(LEAD_CYC - 1);
  localparam logic [CNT_W-1:0] LAG_LD  = CNT_W'(LAG_CYC - 1);
  localparam logic [CNT_W-1:0] GAP_LD  = CNT_W'(GAP_CYC - 1);
  localparam logic [CNT_W-1:0] HALF_LD = CNT_W'(SCK_HALF - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(W - 1);

  seq_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic [BIT_W-1:0] bit_cnt;
  logic             phase2;
  logic             rd_pend;
  logic [W-1:0]     sh;

  // named events for the checker and the top level
  logic cnt_zero, last_bit, reopen;
  assign cnt_zero = (cnt == '0);
  assign last_bit = (bit_cnt == LAST_BIT);
  assign accept   = start && (state == ST_IDLE);
  assign reopen   = (state == ST_GAP) && cnt_zero && rd_pend && !phase2;
  assign fin      = (state == ST_GAP) && cnt_zero && !(rd_pend && !phase2);
  assign busy     = (state != ST_IDLE);
  assign mosi     = sh[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      bit_cnt <= '0;
      phase2  <= 1'b0;
      rd_pend <= 1'b0;
      sh      <= '0;
      rx_word <= '0;
      sck     <= 1'b0;
      cs_n    <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_LEAD;
            cnt     <= LEAD_LD;
            cs_n    <= 1'b0;
            sh      <= tx_word;
            phase2  <= 1'b0;
            rd_pend <= need_rd;
            bit_cnt <= '0;
          end
        end
        ST_LEAD, ST_LOW: begin
          if (cnt_zero) begin
            sck   <= 1'b1;
            state <= ST_HIGH;
            cnt   <= HALF_LD;
            if (phase2) rx_word <= {rx_word[W-2:0], miso};
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_HIGH: begin
          if (cnt_zero) begin
            sck <= 1'b0;
            if (last_bit) begin
              state <= ST_LAG;
              cnt   <= LAG_LD;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
              sh      <= {sh[W-2:0], 1'b0};
              state   <= ST_LOW;
              cnt     <= HALF_LD;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_LAG: begin
          if (cnt_zero) begin
            cs_n  <= 1'b1;
            sh    <= '0;
            state <= ST_GAP;
            cnt   <= GAP_LD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_GAP: begin
          if (cnt_zero) begin
            if (reopen) begin
              cs_n    <= 1'b0;
              sh      <= '0;
              phase2  <= 1'b1;
              bit_cnt <= '0;
              state   <= ST_LEAD;
              cnt     <= LEAD_LD;
            end else begin
              state <= ST_IDLE;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/chain_pot_master.sv
module chain_pot_master
  import chain_pot_pkg::*;
#(
  parameter int N_DEV    = 4,
  parameter int SCK_HALF = 20
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [N_DEV-1:0]          cmd_rd,
  input  logic [N_DEV*5-1:0]        cmd_addr,
  input  logic [N_DEV*8-1:0]        cmd_data,
  output logic                      busy,
  output logic                      done,
  output logic [N_DEV*8-1:0]        rd_data,
  output logic [N_DEV-1:0]          rd_err,
  output logic                      sck,
  output logic                      cs_n,
  output logic                      mosi,
  input  logic                      miso
);
  localparam int W = N_DEV * FRAME_W;

  logic [W-1:0]              tx_word;
  logic [W-1:0]              rx_word;
  logic                      accept;
  logic                      fin;
  logic [N_DEV-1:0]          rd_q;
  logic [N_DEV*ADDR_W-1:0]   addr_q;
  logic [N_DEV*DATA_W-1:0]   res_data;
  logic [N_DEV-1:0]          res_err;

  chain_pot_pack #(.N_DEV(N_DEV)) u_pack (
    .cmd_rd  (cmd_rd),
    .cmd_addr(cmd_addr),
    .cmd_data(cmd_data),
    .tx_word (tx_word)
  );

  chain_pot_engine #(.N_DEV(N_DEV), .SCK_HALF(SCK_HALF)) u_engine (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .need_rd(|cmd_rd),
    .tx_word(tx_word),
    .miso   (miso),
    .sck    (sck),
    .cs_n   (cs_n),
    .mosi   (mosi),
    .busy   (busy),
    .accept (accept),
    .fin    (fin),
    .rx_word(rx_word)
  );

  chain_pot_unpack #(.N_DEV(N_DEV)) u_unpack (
    .rx_word  (rx_word),
    .rd_mask  (rd_q),
    .addr_flat(addr_q),
    .data_flat(res_data),
    .err_flat (res_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= '0;
      addr_q  <= '0;
      rd_data <= '0;
      rd_err  <= '0;
      done    <= 1'b0;
    end else begin
      done <= fin;
      if (accept) begin
        rd_q   <= cmd_rd;
        addr_q <= cmd_addr;
      end
      if (fin) begin
        rd_data <= res_data;
        rd_err  <= res_err;
      end
    end
  end
endmodule

// File: rtl/chain_pot_checker.sv
module chain_pot_checker
  import chain_pot_pkg::*;
#(
  parameter int N_DEV    = 4,
  parameter int SCK_HALF = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sck,
  input logic             cs_n,
  input logic             mosi,
  input logic             busy,
  input logic             done,
  input logic [N_DEV-1:0] rd_err,
  input logic [N_DEV-1:0] rd_q
);
  localparam int GAP_CYC = gap_cycles(SCK_HALF);

  logic [15:0] hi_cnt;
  logic [15:0] csh_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt  <= '0;
      csh_cnt <= 16'(GAP_CYC);
    end else begin
      hi_cnt <= sck ? hi_cnt + 1'b1 : '0;
      if (!cs_n)                      csh_cnt <= '0;
      else if (csh_cnt < 16'(GAP_CYC)) csh_cnt <= csh_cnt + 1'b1;
    end
  end

  p_sck_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);
  p_mosi_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));
  p_sck_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sck) |-> (hi_cnt == 16'(SCK_HALF)));
  p_deselect_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (csh_cnt >= 16'(GAP_CYC)));
  p_idle_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n);
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_err_reader_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((rd_err & ~rd_q) == '0));
endmodule

bind chain_pot_master chain_pot_checker #(.N_DEV(N_DEV), .SCK_HALF(SCK_HALF)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .sck   (sck),
  .cs_n  (cs_n),
  .mosi  (mosi),
  .busy  (busy),
  .done  (done),
  .rd_err(rd_err),
  .rd_q  (rd_q)
);

// File: tb/chain_pot_master_tb.sv
module chain_pot_master_tb;
  localparam int N    = 3;
  localparam int HALF = 2;
  localparam int W    = 16 * N;
  localparam int LEAD = HALF * 3;
  localparam int LAG  = HALF * 3;
  localparam int GAP  = HALF * 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [N-1:0]   cmd_rd = '0;
  logic [N*5-1:0] cmd_addr = '0;
  logic [N*8-1:0] cmd_data = '0;
  logic busy, done, sck, cs_n, mosi;
  logic miso = 1'b0;
  logic [N*8-1:0] rd_data;
  logic [N-1:0]   rd_err;

  always #2.5 clk = ~clk;

  chain_pot_master #(.N_DEV(N), .SCK_HALF(HALF)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_rd(cmd_rd), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .busy(busy), .done(done), .rd_data(rd_data), .rd_err(rd_err),
    .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  int n_tests = 0;
  int n_fail  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---- bus monitor: window captures and miso responder
  int win_idx = 0;
  int rise_cnt = 0;
  int rises[2];
  logic [W-1:0] cap_sh;
  logic [W-1:0] cap[2];
  logic [W-1:0] resp_stream = '0;
  logic [W-1:0] resp_sh = '0;

  always @(posedge sck) if (rst_n) begin
    cap_sh = {cap_sh[W-2:0], mosi};
    rise_cnt++;
  end
  always @(posedge cs_n) if (rst_n) begin
    if (win_idx < 2) begin
      cap[win_idx]   = cap_sh;
      rises[win_idx] = rise_cnt;
    end
    win_idx++;
    rise_cnt = 0;
  end
  always @(negedge cs_n) if (rst_n) begin
    resp_sh = (win_idx == 1) ? resp_stream : '1;
    miso = resp_sh[W-1];
  end
  always @(negedge sck) if (rst_n) begin
    resp_sh = {resp_sh[W-2:0], 1'b0};
    miso = resp_sh[W-1];
  end

  // ---- interval monitor on falling clock edges
  int t_err = 0;
  int run = 0, hi = 0, cs_hi = 1000;
  bit first_rise = 0;
  logic p_sck = 0, p_cs = 1, p_mosi = 0;
  always @(negedge clk) if (rst_n) begin
    if (!cs_n && p_cs) begin
      if (cs_hi < GAP) t_err++;
      run = 0; first_rise = 1;
    end
    if (sck && !p_sck) begin
      if (first_rise ? (run != LEAD) : (run != HALF)) t_err++;
      first_rise = 0; hi = 0;
    end
    if (!sck && p_sck) begin
      if (hi != HALF) t_err++;
      run = 0;
    end
    if (cs_n && !p_cs) begin
      if (run != LAG) t_err++;
      cs_hi = 0;
    end
    if (sck && cs_n) t_err++;
    if (sck && p_sck && (mosi !== p_mosi)) t_err++;
    if (cs_n) cs_hi++; else if (sck) hi++; else run++;
    p_sck = sck; p_cs = cs_n; p_mosi = mosi;
  end

  // ---- transaction model
  logic        t_rd[N];
  logic [4:0]  t_addr[N];
  logic [7:0]  t_data[N];
  logic [7:0]  r_hdr[N];
  logic [7:0]  r_dat[N];

  task automatic issue();
    for (int d = 0; d < N; d++) begin
      cmd_rd[d] = t_rd[d];
      cmd_addr[d*5 +: 5] = t_addr[d];
      cmd_data[d*8 +: 8] = t_data[d];
    end
    // stream k-th received frame is owned by device N-1-k
    for (int k = 0; k < N; k++)
      resp_stream[W-1-16*k -: 16] = {r_hdr[N-1-k], r_dat[N-1-k]};
    win_idx = 0; rise_cnt = 0; t_err = 0; cap_sh = '0;
    cap[0] = '0; cap[1] = '0; rises[0] = 0; rises[1] = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done_and_check();
    logic [W-1:0] exp_tx;
    bit any_rd = 0;
    int guard = 0;
    while (!done && guard < 5000) begin @(negedge clk); guard++; end
    chk(done === 1'b1, "R11", "done seen", 64'(done), 64'd1);
    chk(busy === 1'b0, "R11", "busy at done", 64'(busy), 64'd0);
    for (int k = 0; k < N; k++) begin
      int dv = N - 1 - k;
      exp_tx[W-1-16*k -: 16] = t_rd[dv] ? {3'b100, t_addr[dv], 8'h00}
                                         : {3'b110, t_addr[dv], t_data[dv]};
      any_rd |= t_rd[dv];
    end
    chk(cap[0] === exp_tx, "R2", "first window stream", 64'(cap[0]), 64'(exp_tx));
    chk(rises[0] == W, "R2", "first window edges", 64'(rises[0]), 64'(W));
    chk(win_idx == (any_rd ? 2 : 1), "R6", "window count", 64'(win_idx), any_rd ? 64'd2 : 64'd1);
    if (any_rd) begin
      chk(cap[1] === '0, "R6", "NOP stream", 64'(cap[1]), 64'd0);
      chk(rises[1] == W, "R6", "second window edges", 64'(rises[1]), 64'(W));
    end
    for (int d = 0; d < N; d++) begin
      logic [7:0] ed = t_rd[d] ? r_dat[d] : 8'h00;
      logic ee = t_rd[d] && (r_hdr[d] != {3'b111, t_addr[d]});
      chk(rd_data[d*8 +: 8] === ed, t_rd[d] ? "R7" : "R9", "rd_data", 64'(rd_data[d*8 +: 8]), 64'(ed));
      chk(rd_err[d] === ee, t_rd[d] ? "R8" : "R9", "rd_err", 64'(rd_err[d]), 64'(ee));
    end
    chk(t_err == 0, "R5", "bus intervals and R4 mode-0 rules", 64'(t_err), 64'd0);
    @(negedge clk);
    chk(done === 1'b0, "R11", "done single cycle", 64'(done), 64'd0);
  endtask

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(cs_n === 1'b1 && sck === 1'b0 && mosi === 1'b0, "R1", "bus idle",
        64'({cs_n, sck, mosi}), 64'b100);
    chk(busy === 1'b0 && done === 1'b0, "R1", "flags", 64'({busy, done}), 64'd0);
    chk(rd_data === '0 && rd_err === '0, "R1", "results", 64'({rd_data, rd_err}), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // sweep every read mask with mixed good and corrupted echoes (R2 R3 R6 R7 R8 R9)
    for (int rep = 0; rep < 2; rep++) begin
      for (int m = 0; m < (1 << N); m++) begin
        for (int d = 0; d < N; d++) begin
          int sel = (m + d + rep) % 3;
          t_rd[d]   = m[d];
          t_addr[d] = 5'((m * 5 + d * 7 + rep * 3) % 32);
          t_data[d] = 8'(m * 37 + d * 11 + rep * 91);
          r_dat[d]  = ~t_data[d] ^ 8'(d + 1);
          r_hdr[d]  = (sel == 0) ? {3'b111, t_addr[d]} :
                      (sel == 1) ? {3'b110, t_addr[d]} :
                                   {3'b111, t_addr[d] ^ 5'd1};
        end
        issue();
        wait_done_and_check();
      end
    end

    // R10: start during a running transaction is ignored
    for (int d = 0; d < N; d++) begin
      t_rd[d] = 1'b0; t_addr[d] = 5'(d); t_data[d] = 8'(8'hA0 + d);
      r_hdr[d] = 8'h00; r_dat[d] = 8'h00;
    end
    issue();
    repeat (60) @(negedge clk);
    cmd_rd = '1; cmd_addr = '1; cmd_data = '1;
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    wait_done_and_check();
    repeat (3 * GAP) @(negedge clk);
    chk(win_idx == 1, "R10", "no extra window", 64'(win_idx), 64'd1);
    chk(cs_n === 1'b1 && busy === 1'b0, "R10", "stays idle", 64'({cs_n, busy}), 64'b10);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule